// File: doc/BRIEF.md
# Per-Line Scanline Setup Controller

This block sets up each scanline of a framebuffer video generator from a table held in memory. The table has one 32-bit word for every display line. When the timing generator signals the horizontal blanking before a line, the block reads that line's word through a simple request/acknowledge read port and holds it until the active region begins. When the active region starts, it decodes the word. It then presents the line's start address, graphics mode and palette index to the pixel pipeline, and pulses an interrupt request if the word asks for one.

The list is turned on by the top bit of a control word, and the lower bits of that word give the table base. When the list is off, or a fetched word is not marked valid, the line takes its settings from global registers instead. The global start address advances by a fixed line stride per line. If memory does not answer before the active region begins, the line keeps the settings of the previous line.

Top module: `scanline_list_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `mem_req`, `line_irq`, `line_addr`, `line_mode` and `line_pal` are all zero.
- R2: A `fetch_go` pulse with `list_ctrl[31]`=1 raises `mem_req` in the next cycle, with `mem_addr` = (`list_ctrl[30:0]` + `fetch_line`) truncated to ADDR_W bits. `mem_addr` stays unchanged while the request is open.
- R3: `mem_ack` high while `mem_req` is high, in a cycle with no `fetch_go` or `line_go`, captures `mem_rdata` as the line's entry and lowers `mem_req` in the next cycle.
- R4: At `line_go` with a captured entry whose bit 31 is 1, the outputs in the next cycle are `line_addr` = entry[17:0] shifted left by 2, `line_mode` = entry[21:18] and `line_pal` = entry[29:22].
- R5: `line_irq` is high for exactly the one cycle after `line_go`, and only when the captured entry has both bit 31 and bit 30 set. Bit 30 with bit 31 clear gives no pulse.
- R6: At `line_go` with a captured entry whose bit 31 is 0, the outputs become `glb_start` + line×`glb_stride` (ADDR_W bits), `glb_mode` and `glb_pal`, where line is the `fetch_line` given at the preceding `fetch_go`.
- R7: A `fetch_go` with `list_ctrl[31]`=0 issues no request, and the following `line_go` applies the global values as in R6.
- R8: If no acknowledge was accepted before `line_go`, `mem_req` is withdrawn in the next cycle and the outputs keep their previous values. An acknowledge that arrives in the `line_go` cycle is ignored.
- R9: `line_addr`, `line_mode` and `line_pal` change only in the cycle after a `line_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| list_ctrl | input | 32 | Bit 31 enables the list; bits 30..0 give the table base word address |
| glb_start | input | ADDR_W | Global frame start address |
| glb_stride | input | ADDR_W | Address increment per line for the global start |
| glb_mode | input | 4 | Global graphics mode |
| glb_pal | input | 8 | Global palette index |
| fetch_go | input | 1 | One-cycle pulse at the start of horizontal blanking before a line |
| fetch_line | input | LINE_W | Index of the line that follows, valid with `fetch_go` |
| line_go | input | 1 | One-cycle pulse at the start of that line's active region |
| mem_req | output | 1 | Read request to the memory controller |
| mem_addr | output | ADDR_W | Word address of the requested entry |
| mem_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata | input | 32 | Entry word read from memory |
| line_addr | output | ADDR_W | Start address for the current line |
| line_mode | output | 4 | Graphics mode for the current line |
| line_pal | output | 8 | Palette index for the current line |
| line_irq | output | 1 | One-cycle per-line interrupt request |

## Verification
The block is run through a series of lines, and each line takes a different path. There are valid entries with and without the interrupt bit, and an entry with only the interrupt bit set, which shows that validity gates the pulse. An invalid entry and a disabled list both fall back to the global registers, and a non-zero line index shows that the stride is applied. Memory latency is also varied. A short delay is accepted. No acknowledge at all, and an acknowledge that lands exactly on the start of the active region, must both leave the previous line's settings in place. This separates a hold from a late capture.

// File: rtl/scanline_list_pkg.sv
// Shared field positions and decode for one display-list entry.
// Assumes a 32-bit entry word with the layout fixed by the pixel pipeline.
package scanline_list_pkg;

    localparam int ENTRY_W   = 32;
    localparam int VALID_BIT = 31;
    localparam int IRQ_BIT   = 30;
    localparam int PAL_LSB   = 22;
    localparam int PAL_W     = 8;
    localparam int MODE_LSB  = 18;
    localparam int MODE_W    = 4;
    localparam int SADR_W    = 18;
    localparam int SADR_SHL  = 2;

    typedef struct packed {
        logic              valid;
        logic              irq;
        logic [PAL_W-1:0]  pal;
        logic [MODE_W-1:0] mode;
        logic [SADR_W-1:0] sadr;
    } entry_t;

    // Split a raw entry word into its fields.
    function automatic entry_t decode_entry(input logic [ENTRY_W-1:0] w);
        entry_t e;
        e.valid = w[VALID_BIT];
        e.irq   = w[IRQ_BIT];
        e.pal   = w[PAL_LSB +: PAL_W];
        e.mode  = w[MODE_LSB +: MODE_W];
        e.sadr  = w[SADR_W-1:0];
        return e;
    endfunction

endpackage

// File: rtl/scanline_list_fetch.sv
// Entry fetcher: opens a read for the next line at fetch_go, keeps the
// address steady until acknowledge or line_go, and captures the entry.
// Assumes fetch_go and line_go never share a cycle; fetch_go wins if they do.
module scanline_list_fetch #(
    parameter int ADDR_W = 20,
    parameter int LINE_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          list_ctrl,
    input  logic                 fetch_go,
    input  logic [LINE_W-1:0]    fetch_line,
    input  logic                 line_go,
    input  logic                 mem_ack,
    input  logic [31:0]          mem_rdata,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 list_on,
    output logic                 have_entry,
    output logic [31:0]          entry_word,
    output logic [LINE_W-1:0]    cur_line
);

    logic [30:0] addr_sum;

    // Table address of the upcoming line's entry.
    always_comb addr_sum = list_ctrl[30:0] + 31'(fetch_line);

    // Request/acknowledge sequencing and entry capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req    <= 1'b0;
            mem_addr   <= '0;
            list_on    <= 1'b0;
            have_entry <= 1'b0;
            entry_word <= '0;
            cur_line   <= '0;
        end else if (fetch_go) begin
            mem_req    <= list_ctrl[31];
            mem_addr   <= addr_sum[ADDR_W-1:0];
            list_on    <= list_ctrl[31];
            have_entry <= 1'b0;
            cur_line   <= fetch_line;
        end else if (line_go) begin
            mem_req    <= 1'b0;
            have_entry <= 1'b0;
        end else if (mem_req && mem_ack) begin
            mem_req    <= 1'b0;
            have_entry <= 1'b1;
            entry_word <= mem_rdata;
        end
    end

endmodule

// File: rtl/scanline_list_apply.sv
// Line settings register: at line_go picks list fields, global values or a
// hold of the previous line, and pulses the per-line interrupt.
// Assumes the fetcher's state is final in the line_go cycle.
module scanline_list_apply
    import scanline_list_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LINE_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_go,
    input  logic                 list_on,
    input  logic                 have_entry,
    input  logic [31:0]          entry_word,
    input  logic [LINE_W-1:0]    cur_line,
    input  logic [ADDR_W-1:0]    glb_start,
    input  logic [ADDR_W-1:0]    glb_stride,
    input  logic [MODE_W-1:0]    glb_mode,
    input  logic [PAL_W-1:0]     glb_pal,
    output logic [ADDR_W-1:0]    line_addr,
    output logic [MODE_W-1:0]    line_mode,
    output logic [PAL_W-1:0]     line_pal,
    output logic                 line_irq
);

    entry_t            ent;
    logic [ADDR_W-1:0] glb_line_addr;
    logic [ADDR_W-1:0] ent_addr;
    logic              use_list;
    logic              use_glb;

    // Decode fields and form both candidate start addresses.
    always_comb begin
        ent           = decode_entry(entry_word);
        ent_addr      = ADDR_W'({ent.sadr, {SADR_SHL{1'b0}}});
        glb_line_addr = glb_start + ADDR_W'(ADDR_W'(cur_line) * glb_stride);
        use_list      = list_on && have_entry && ent.valid;
        use_glb       = !list_on || (have_entry && !ent.valid);
    end

    // Load the line settings at the start of the active region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_addr <= '0;
            line_mode <= '0;
            line_pal  <= '0;
            line_irq  <= 1'b0;
        end else begin
            line_irq <= line_go && use_list && ent.irq;
            if (line_go && use_list) begin
                line_addr <= ent_addr;
                line_mode <= ent.mode;
                line_pal  <= ent.pal;
            end else if (line_go && use_glb) begin
                line_addr <= glb_line_addr;
                line_mode <= glb_mode;
                line_pal  <= glb_pal;
            end
        end
    end

endmodule

// File: rtl/scanline_list_ctrl.sv
// Top of the per-line display list controller: fetcher plus line settings
// register. Assumes ADDR_W >= 20 and ADDR_W <= 31, LINE_W <= 31.
module scanline_list_ctrl #(
    parameter int ADDR_W = 20,
    parameter int LINE_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          list_ctrl,
    input  logic [ADDR_W-1:0]    glb_start,
    input  logic [ADDR_W-1:0]    glb_stride,
    input  logic [3:0]           glb_mode,
    input  logic [7:0]           glb_pal,
    input  logic                 fetch_go,
    input  logic [LINE_W-1:0]    fetch_line,
    input  logic                 line_go,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic [31:0]          mem_rdata,
    output logic [ADDR_W-1:0]    line_addr,
    output logic [3:0]           line_mode,
    output logic [7:0]           line_pal,
    output logic                 line_irq
);

    logic              list_on;
    logic              have_entry;
    logic [31:0]       entry_word;
    logic [LINE_W-1:0] cur_line;

    scanline_list_fetch #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .list_ctrl(list_ctrl),
        .fetch_go(fetch_go), .fetch_line(fetch_line), .line_go(line_go),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .list_on(list_on), .have_entry(have_entry),
        .entry_word(entry_word), .cur_line(cur_line)
    );

    scanline_list_apply #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_apply (
        .clk(clk), .rst_n(rst_n), .line_go(line_go),
        .list_on(list_on), .have_entry(have_entry),
        .entry_word(entry_word), .cur_line(cur_line),
        .glb_start(glb_start), .glb_stride(glb_stride),
        .glb_mode(glb_mode), .glb_pal(glb_pal),
        .line_addr(line_addr), .line_mode(line_mode),
        .line_pal(line_pal), .line_irq(line_irq)
    );

endmodule

// File: rtl/scanline_list_ctrl_chk.sv
// Protocol and timing properties of the scanline setup controller,
// attached to every instance of the top by the bind below.
module scanline_list_ctrl_chk #(
    parameter int ADDR_W = 20,
    parameter int LINE_W = 11
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fetch_go,
    input logic                 line_go,
    input logic                 mem_req,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic                 mem_ack,
    input logic [ADDR_W-1:0]    line_addr,
    input logic [3:0]           line_mode,
    input logic [7:0]           line_pal,
    input logic                 line_irq
);

    assert_req_from_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(fetch_go));

    assert_addr_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !fetch_go) |=> $stable(mem_addr));

    assert_ack_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !fetch_go) |=> !mem_req);

    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq |=> !line_irq);

    assert_irq_after_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq |-> $past(line_go));

    assert_withdraw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && line_go && !fetch_go) |=> !mem_req);

    assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(line_go) |-> ($stable(line_addr) && $stable(line_mode) && $stable(line_pal)));

endmodule

bind scanline_list_ctrl scanline_list_ctrl_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go), .line_go(line_go),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .line_addr(line_addr), .line_mode(line_mode), .line_pal(line_pal),
    .line_irq(line_irq)
);

// File: tb/scanline_list_ctrl_tb.sv
module scanline_list_ctrl_tb;

    localparam int AW = 20;
    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   list_ctrl = '0;
    logic [AW-1:0] glb_start = 20'h01000;
    logic [AW-1:0] glb_stride = 20'h00280;
    logic [3:0]    glb_mode = 4'h3;
    logic [7:0]    glb_pal = 8'h5A;
    logic          fetch_go = 1'b0;
    logic [LW-1:0] fetch_line = '0;
    logic          line_go = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic [AW-1:0] line_addr;
    logic [3:0]    line_mode;
    logic [7:0]    line_pal;
    logic          line_irq;

    int errors = 0;
    int checks = 0;
    string tag = "R1";
    bit done = 0;

    logic [31:0] table_mem [64];
    int ack_delay = 1;
    int req_cnt = 0;

    // reference model state
    bit          m_req, m_en, m_have, m_irq;
    logic [31:0] m_entry;
    int          m_line;
    logic [AW-1:0] m_maddr, m_addr;
    logic [3:0]  m_mode;
    logic [7:0]  m_pal;

    always #10 clk = ~clk;

    scanline_list_ctrl #(.ADDR_W(AW), .LINE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .list_ctrl(list_ctrl),
        .glb_start(glb_start), .glb_stride(glb_stride),
        .glb_mode(glb_mode), .glb_pal(glb_pal),
        .fetch_go(fetch_go), .fetch_line(fetch_line), .line_go(line_go),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .line_addr(line_addr), .line_mode(line_mode),
        .line_pal(line_pal), .line_irq(line_irq)
    );

    // Behavioural expectation of every output, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_req = 0; m_en = 0; m_have = 0; m_irq = 0; m_entry = 0; m_line = 0;
            m_maddr = 0; m_addr = 0; m_mode = 0; m_pal = 0;
        end else begin
            m_irq = 0;
            if (fetch_go) begin
                m_line  = int'(fetch_line);
                m_en    = list_ctrl[31];
                m_req   = list_ctrl[31];
                m_have  = 0;
                m_maddr = AW'(int'(list_ctrl[30:0]) + m_line);
            end else if (line_go) begin
                if (!m_en || (m_have && !m_entry[31])) begin
                    m_addr = AW'(int'(glb_start) + m_line * int'(glb_stride));
                    m_mode = glb_mode;
                    m_pal  = glb_pal;
                end else if (m_have) begin
                    m_addr = AW'(int'(m_entry[17:0]) * 4);
                    m_mode = m_entry[21:18];
                    m_pal  = m_entry[29:22];
                    m_irq  = m_entry[30];
                end
                m_req = 0; m_have = 0;
            end else if (m_req && mem_ack) begin
                m_req = 0; m_have = 1; m_entry = mem_rdata;
            end
        end
    end

    // Memory responder: acknowledges after ack_delay cycles of open request.
    always @(negedge clk) begin
        if (mem_req) begin
            req_cnt = req_cnt + 1;
            mem_ack <= (req_cnt == ack_delay);
            mem_rdata <= table_mem[mem_addr[5:0]];
        end else begin
            req_cnt = 0;
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("mem_req", 32'(mem_req), 32'(m_req));
            if (m_req) chk("mem_addr", 32'(mem_addr), 32'(m_maddr));
            chk("line_addr R9", 32'(line_addr), 32'(m_addr));
            chk("line_mode R9", 32'(line_mode), 32'(m_mode));
            chk("line_pal R9", 32'(line_pal), 32'(m_pal));
            chk("line_irq", 32'(line_irq), 32'(m_irq));
        end
    end

    task automatic run_line(input int ln, input logic [31:0] ctrl, input int gap);
        @(negedge clk);
        list_ctrl = ctrl; fetch_line = LW'(ln); fetch_go = 1'b1;
        @(negedge clk);
        fetch_go = 1'b0;
        repeat (gap) @(negedge clk);
        line_go = 1'b1;
        @(negedge clk);
        line_go = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) table_mem[i] = 32'h0;
        // base 8: line 2 -> idx 10 etc.
        table_mem[10] = {1'b1, 1'b0, 8'hC3, 4'h7, 18'h01234};
        table_mem[11] = {1'b1, 1'b1, 8'h11, 4'h2, 18'h3FFFF};
        table_mem[12] = {1'b0, 1'b1, 8'hEE, 4'hF, 18'h00055};
        table_mem[13] = {1'b0, 1'b0, 8'h99, 4'h9, 18'h00AAA};
        table_mem[14] = {1'b1, 1'b1, 8'h77, 4'h1, 18'h00010};

        // R1: reset state, during and right after reset
        tag = "R1";
        repeat (3) @(negedge clk);
        chk("reset mem_req", 32'(mem_req), 0);
        chk("reset line_addr", 32'(line_addr), 0);
        chk("reset irq", 32'(line_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("post-reset mode/pal", {24'h0, line_mode, 4'h0} | 32'(line_pal), 0);

        // R2 R3 R4: valid entry, acknowledged after two cycles
        tag = "R4"; ack_delay = 2;
        run_line(2, 32'h8000_0008, 5);
        chk("R4 addr", 32'(line_addr), 32'h0_48D0);
        chk("R4 mode", 32'(line_mode), 32'h7);
        chk("R4 pal", 32'(line_pal), 32'hC3);

        // R5: valid entry with interrupt bit, maximum start field
        tag = "R5"; ack_delay = 1;
        run_line(3, 32'h8000_0008, 4);

        // R5 R6: interrupt bit without valid gives globals and no pulse
        tag = "R6";
        run_line(4, 32'h8000_0008, 4);
        chk("R6 global addr", 32'(line_addr), 32'(20'h01000 + 4 * 20'h00280));

        // R6: invalid entry, other line
        run_line(5, 32'h8000_0008, 4);

        // R7: list disabled
        tag = "R7";
        run_line(9, 32'h0000_0008, 4);
        chk("R7 global addr", 32'(line_addr), 32'(20'h01000 + 9 * 20'h00280));

        // R8: no acknowledge at all -> hold previous settings
        tag = "R8"; ack_delay = 99;
        run_line(6, 32'h8000_0008, 4);
        chk("R8 hold addr", 32'(line_addr), 32'(20'h01000 + 9 * 20'h00280));

        // R8: acknowledge landing in the line_go cycle is ignored
        ack_delay = 4;
        run_line(6, 32'h8000_0008, 3);
        chk("R8 late ack mode", 32'(line_mode), 32'h3);

        // R3: restore normal latency, entry with interrupt again
        tag = "R3"; ack_delay = 3;
        run_line(6, 32'h8000_0008, 6);
        chk("R3 addr", 32'(line_addr), 32'h0_0040);

        // R2: base wraps modulo address width
        tag = "R2"; ack_delay = 1;
        run_line(3, 32'h800F_FFFF, 4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule